// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit-Slip

This block gathers a serial bit stream into 8-bit parallel words and drives a framing clock with one period per word. Two serial sources feed it, and a select input picks one. A rate input sets how many bits arrive per clock. In single-rate mode one bit is taken on each rising edge from bit 0 of the chosen source. In double-rate mode both bits of the 2-bit source are taken on each edge, and bit 0 counts as the earlier bit.

A slip request realigns the word boundary. It passes through a two-flop synchronizer. Once it has been seen high for the required number of consecutive clocks, exactly one incoming bit is dropped, so every later word moves by one bit position. A synchronous enable freezes all progress. An asynchronous reset clears the block, and capture begins shortly after reset is released. The rate and the source select are static settings and change only while reset is held.

Top module: `sd_deser`

## Requirements
- R1: The first bit taken after alignment lands on `word_q[0]`, the next on `word_q[1]`, and so on up to `word_q[7]`. In double-rate mode (`dr_mode`=1), `ser_x[0]` of a pair is the earlier bit and `ser_x[1]` the later.
- R2: With `src_sel`=0 the block reads `ser_a`, and with `src_sel`=1 it reads `ser_b`. The unselected source has no effect on `word_q`.
- R3: `frame_clk` has a period of 4 clocks in double-rate mode and 8 clocks in single-rate mode. It rises on the edge that takes bit 0 of a word and stays high for half the period. `word_q` changes only on an edge where `frame_clk` falls.
- R4: The edge that updates `word_q` with a word comes 6 clocks (double-rate) or 12 clocks (single-rate) after the edge that took that word's bit 0.
- R5: A slip happens only after the synchronized `slip_req` has been high for at least 2 consecutive enabled clocks (double-rate) or 3 (single-rate). A shorter pulse has no effect. A qualified request drops exactly one bit, which shifts all later words by one position.
- R6: A request held high for any length causes one slip. Each further slip needs `slip_req` to go low and then high again.
- R7: `rst` is asynchronous. It forces `word_q` and `frame_clk` to 0 at once. After release, the first bit is taken on the second rising edge.
- R8: While `en` is low, `word_q`, `frame_clk`, the bit position and the partial word all hold, and no serial bit is taken. After `en` returns high, capture resumes on the next edge with no bit lost from the accepted stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Synchronous enable; low freezes the block |
| dr_mode | input | 1 | 1 = two bits per clock, 0 = one bit per clock |
| src_sel | input | 1 | 0 = `ser_a`, 1 = `ser_b` |
| ser_a | input | 2 | Serial source A (bit 0 earlier) |
| ser_b | input | 2 | Serial source B (bit 0 earlier) |
| slip_req | input | 1 | Bit-slip request, may be asynchronous |
| word_q | output | W | Registered parallel word |
| frame_clk | output | 1 | Registered word-framing clock |

## Verification
The slip-hold properties check the default hold lengths of 2 and 3 with fixed look-back depths. They also assume that `dr_mode` does not change while a request is being counted. The reset property assumes `rst` is high at the first clock edge. The stimulus keeps within these limits. It changes rate and source only inside a reset window, and it drives every input shortly after a rising edge so each value is stable for the next edge. Random data, random enable gaps and slip pulses both shorter and longer than the threshold are compared against a bit-accurate reference model held in the bench.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_DOUBLE = 1'b1
  } rate_e;

  localparam int unsigned SD_WORD_W  = 8;
  localparam int unsigned SD_HOLD_DR = 2;
  localparam int unsigned SD_HOLD_SR = 3;
endpackage

// File: rtl/sd_slip_qual.sv
module sd_slip_qual
  import sd_pkg::*;
#(
  parameter int HOLD_DR = 2,
  parameter int HOLD_SR = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  rate_e rate,
  input  logic  req,
  output logic  swallow
);
  localparam int HMAX = (HOLD_DR > HOLD_SR) ? HOLD_DR : HOLD_SR;
  localparam int CW   = $clog2(HMAX + 1);

  logic          s1, s2;
  logic [CW-1:0] hcnt;
  logic          used;
  logic [CW-1:0] need;

  // hcnt counts earlier synchronized-high edges; the current one completes the hold
  assign need    = (rate == RATE_DOUBLE) ? CW'(HOLD_DR - 1) : CW'(HOLD_SR - 1);
  assign swallow = en & s2 & (hcnt == need) & ~used;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      hcnt <= '0;
      used <= 1'b0;
    end else begin
      s1 <= req;
      s2 <= s1;
      if (!s2) begin
        hcnt <= '0;
        used <= 1'b0;
      end else if (en) begin
        if (swallow)
          used <= 1'b1;
        else if (hcnt != need)
          hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sd_frame_seq.sv
module sd_frame_seq
  import sd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  rate_e                rate,
  input  logic                 stall,
  output logic                 cap,
  output logic [$clog2(W)-1:0] phase,
  output logic                 frame_clk
);
  localparam int KD = W / 2;
  localparam int PW = $clog2(W);

  logic          warm;
  logic [PW-1:0] last_ph;
  logic [PW-1:0] half;

  assign last_ph = (rate == RATE_DOUBLE) ? PW'(KD - 1) : PW'(W - 1);
  assign half    = (rate == RATE_DOUBLE) ? PW'(KD / 2) : PW'(W / 2);
  assign cap     = en & warm & ~stall;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      warm      <= 1'b0;
      phase     <= '0;
      frame_clk <= 1'b0;
    end else begin
      if (en) warm <= 1'b1;
      if (cap) begin
        phase     <= (phase == last_ph) ? '0 : phase + 1'b1;
        frame_clk <= (phase < half);
      end
    end
  end
endmodule

// File: rtl/sd_word_asm.sv
module sd_word_asm
  import sd_pkg::*;
#(
  parameter int W      = 8,
  parameter int LAT_DR = 6,
  parameter int LAT_SR = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rate_e                rate,
  input  logic                 src_sel,
  input  logic [1:0]           ser_a,
  input  logic [1:0]           ser_b,
  input  logic                 swallow,
  input  logic                 cap,
  input  logic [$clog2(W)-1:0] phase,
  output logic                 stall,
  output logic [W-1:0]         word_q
);
  localparam int KD    = W / 2;
  localparam int PW    = $clog2(W);
  localparam int OPH_D = LAT_DR % KD;
  localparam int OPH_S = LAT_SR % W;

  logic [1:0]   din;
  logic         odd, pend;
  logic         keep_pend;
  logic         e_bit, l_bit;
  logic [W-1:0] acc, nacc, hold;
  logic         last_slot, out_slot;

  assign din       = src_sel ? ser_b : ser_a;
  assign stall     = swallow & ((rate == RATE_SINGLE) | ~odd);
  assign keep_pend = odd & ~swallow;
  assign e_bit     = keep_pend ? pend   : din[0];
  assign l_bit     = keep_pend ? din[0] : din[1];

  generate
    for (genvar i = 0; i < W; i++) begin : g_slot
      localparam bit LATE = (i % 2) == 1;
      assign nacc[i] = (rate == RATE_DOUBLE)
                     ? ((phase == PW'(i / 2)) ? (LATE ? l_bit : e_bit) : acc[i])
                     : ((phase == PW'(i))     ? din[0]                 : acc[i]);
    end
  endgenerate

  assign last_slot = (rate == RATE_DOUBLE) ? (phase == PW'(KD - 1)) : (phase == PW'(W - 1));
  assign out_slot  = (rate == RATE_DOUBLE) ? (phase == PW'(OPH_D))  : (phase == PW'(OPH_S));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      odd    <= 1'b0;
      pend   <= 1'b0;
      acc    <= '0;
      hold   <= '0;
      word_q <= '0;
    end else begin
      if (rate == RATE_SINGLE) begin
        odd <= 1'b0;
      end else if (swallow) begin
        odd <= ~odd;
        if (!odd) pend <= din[1];
      end else if (cap && odd) begin
        pend <= din[1];
      end
      if (cap) begin
        acc <= nacc;
        if (last_slot) hold   <= nacc;
        if (out_slot)  word_q <= hold;
      end
    end
  end
endmodule

// File: rtl/sd_deser.sv
module sd_deser
  import sd_pkg::*;
#(
  parameter int W       = SD_WORD_W,
  parameter int LAT_DR  = 6,
  parameter int LAT_SR  = 12,
  parameter int HOLD_DR = SD_HOLD_DR,
  parameter int HOLD_SR = SD_HOLD_SR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         dr_mode,
  input  logic         src_sel,
  input  logic [1:0]   ser_a,
  input  logic [1:0]   ser_b,
  input  logic         slip_req,
  output logic [W-1:0] word_q,
  output logic         frame_clk
);
  localparam int PW = $clog2(W);

  rate_e         rate;
  logic          swallow;
  logic          stall;
  logic          cap;
  logic [PW-1:0] phase;

  assign rate = rate_e'(dr_mode);

  sd_slip_qual #(.HOLD_DR(HOLD_DR), .HOLD_SR(HOLD_SR)) u_qual (
    .clk(clk), .rst(rst), .en(en), .rate(rate), .req(slip_req), .swallow(swallow)
  );

  sd_frame_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .en(en), .rate(rate), .stall(stall),
    .cap(cap), .phase(phase), .frame_clk(frame_clk)
  );

  sd_word_asm #(.W(W), .LAT_DR(LAT_DR), .LAT_SR(LAT_SR)) u_asm (
    .clk(clk), .rst(rst), .rate(rate), .src_sel(src_sel), .ser_a(ser_a), .ser_b(ser_b),
    .swallow(swallow), .cap(cap), .phase(phase), .stall(stall), .word_q(word_q)
  );
endmodule

// File: rtl/sd_deser_chk.sv
module sd_deser_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         dr_mode,
  input logic         slip_req,
  input logic         swallow,
  input logic [W-1:0] word_q,
  input logic         frame_clk
);
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |-> (word_q == '0 && !frame_clk));

  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(word_q) && $stable(frame_clk)));

  p_word_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_q) |-> $fell(frame_clk));

  p_single_slip_r6: assert property (@(posedge clk) disable iff (rst)
    swallow |=> !swallow);

  // depths match the default hold lengths of 2 and 3
  p_slip_hold_dr_r5: assert property (@(posedge clk) disable iff (rst)
    (swallow && dr_mode) |-> ($past(slip_req, 2) && $past(slip_req, 3)));

  p_slip_hold_sr_r5: assert property (@(posedge clk) disable iff (rst)
    (swallow && !dr_mode) |-> ($past(slip_req, 2) && $past(slip_req, 3) && $past(slip_req, 4)));
endmodule

bind sd_deser sd_deser_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .dr_mode(dr_mode), .slip_req(slip_req),
  .swallow(swallow), .word_q(word_q), .frame_clk(frame_clk)
);

// File: tb/tb_sd_deser.sv
`timescale 1ns/1ps
module tb_sd_deser;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b1;
  logic         dr_mode = 1'b1;
  logic         src_sel = 1'b0;
  logic         slip_req = 1'b0;
  logic [1:0]   ser_a = 2'b00;
  logic [1:0]   ser_b = 2'b00;
  logic [W-1:0] word_q;
  logic         frame_clk;

  always #2 clk = ~clk;

  sd_deser dut (
    .clk(clk), .rst(rst), .en(en), .dr_mode(dr_mode), .src_sel(src_sel),
    .ser_a(ser_a), .ser_b(ser_b), .slip_req(slip_req), .word_q(word_q), .frame_clk(frame_clk)
  );

  int    checks = 0, fails = 0, cyc = 0, rel_cyc = 0;
  string cur_tag = "R1";
  bit    done = 0;

  // reference model state
  bit       m_warm, m_odd, m_pend, m_s1, m_s2, m_used, m_en_last;
  int       m_hc, need;
  bit [1:0] din;
  bit       sw;
  bit       exp_bits [8192];
  int       nb;
  int       start_cyc [1024];

  // monitor state
  int           nfall, first_rise;
  bit           prev_fc;
  logic [W-1:0] prev_wq;
  int           fall_cyc [1024];
  logic [W-1:0] fall_word [1024];

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic void push(bit b);
    if (nb % 8 == 0) start_cyc[nb / 8] = cyc;
    exp_bits[nb] = b;
    nb++;
  endfunction

  function automatic logic [W-1:0] exp_word(int j);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = exp_bits[8 * j + i];
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    m_en_last = en;
    if (rst) begin
      m_warm = 0; m_odd = 0; m_pend = 0; m_s1 = 0; m_s2 = 0; m_used = 0; m_hc = 0; nb = 0;
    end else begin
      need = dr_mode ? 1 : 2;
      sw   = en && m_s2 && (m_hc == need) && !m_used;
      if (!m_s2) begin
        m_hc = 0; m_used = 0;
      end else if (en) begin
        if (sw) m_used = 1;
        else if (m_hc != need) m_hc++;
      end
      m_s2 = m_s1;
      m_s1 = slip_req;
      if (en) begin
        if (m_warm) begin
          din = src_sel ? ser_b : ser_a;
          if (dr_mode) begin
            if (m_odd) begin
              if (sw) begin m_odd = 0; push(din[0]); push(din[1]); end
              else begin push(m_pend); push(din[0]); m_pend = din[1]; end
            end else if (sw) begin
              m_odd = 1; m_pend = din[1];
            end else begin
              push(din[0]); push(din[1]);
            end
          end else if (!sw) begin
            push(din[0]);
          end
        end
        m_warm = 1;
      end
    end
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: run hung at cycle %0d (R8 flow)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      nfall = 0; prev_fc = 0; first_rise = -1; prev_wq = word_q;
    end else begin
      if (!m_en_last) begin
        chk(word_q == prev_wq, "R8 word hold", word_q, prev_wq);
        chk(frame_clk == prev_fc, "R8 frame hold", frame_clk, prev_fc);
      end
      if (frame_clk && !prev_fc && first_rise < 0) first_rise = cyc;
      if (!frame_clk && prev_fc && nfall < 1024) begin
        fall_cyc[nfall]  = cyc;
        fall_word[nfall] = word_q;
        if (nfall == 0) chk(word_q == '0, "R7 first frame empty", word_q, 0);
        else if (nb >= 8 * nfall) chk(word_q == exp_word(nfall - 1), cur_tag, word_q, exp_word(nfall - 1));
        nfall++;
      end
      prev_fc = frame_clk;
      prev_wq = word_q;
    end
  end

  task automatic reset_dut(bit dr, bit sel);
    @(posedge clk); #1;
    rst = 1; en = 1; slip_req = 0;
    #0.5;
    chk(word_q == '0, "R7 async clear word", word_q, 0);
    chk(frame_clk == 1'b0, "R7 async clear frame", frame_clk, 0);
    dr_mode = dr; src_sel = sel;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    rel_cyc = cyc;
  endtask

  task automatic step(bit req, bit enable);
    @(posedge clk); #1;
    ser_a = 2'($urandom); ser_b = 2'($urandom);
    slip_req = req; en = enable;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(0, 1);
  endtask

  task automatic pulse(int h);
    for (int i = 0; i < h; i++) step(1, 1);
    run(12);
  endtask

  initial begin
    int seed_v;
    logic [7:0] pat;
    seed_v = $urandom(32'h1f2e3d);

    // double rate, source A, directed byte first
    pat = 8'hC1;
    reset_dut(1, 0);
    cur_tag = "R1";
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      ser_a = pat[2*k +: 2]; ser_b = 2'($urandom);
    end
    run(200);
    chk(fall_word[1] == pat, "R1 bit order", fall_word[1], pat);
    chk(fall_cyc[1] - start_cyc[0] == 6, "R4 latency double", fall_cyc[1] - start_cyc[0], 6);
    chk(fall_cyc[3] - fall_cyc[2] == 4, "R3 period double", fall_cyc[3] - fall_cyc[2], 4);
    chk(first_rise - rel_cyc == 2, "R7 first capture edge", first_rise - rel_cyc, 2);

    // single rate, source B
    pat = 8'h4B;
    reset_dut(0, 1);
    cur_tag = "R2";
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      ser_b = {1'b0, pat[k]}; ser_a = 2'($urandom);
    end
    run(300);
    chk(fall_word[1] == pat, "R2 source B order", fall_word[1], pat);
    chk(fall_cyc[1] - start_cyc[0] == 12, "R4 latency single", fall_cyc[1] - start_cyc[0], 12);
    chk(fall_cyc[4] - fall_cyc[3] == 8, "R3 period single", fall_cyc[4] - fall_cyc[3], 8);
    chk(first_rise - rel_cyc == 2, "R7 first capture edge single", first_rise - rel_cyc, 2);

    // double-rate slips: short pulse, minimum pulse, held pulse, back-to-back
    reset_dut(1, 0);
    cur_tag = "R5";
    run(30); pulse(1); run(20); pulse(2); run(20);
    cur_tag = "R6";
    pulse(15); run(20); pulse(3); pulse(2); run(40);

    // single-rate slips
    reset_dut(0, 0);
    cur_tag = "R5";
    run(40); pulse(2); run(30); pulse(3); run(30);
    cur_tag = "R6";
    pulse(25); run(30); pulse(4); run(40);

    // enable freezes in both rates
    reset_dut(1, 1);
    cur_tag = "R8";
    run(10);
    for (int i = 0; i < 300; i++) step(0, ($urandom % 4) != 0);
    for (int i = 0; i < 9; i++) step(0, 0);
    run(30);
    reset_dut(0, 0);
    run(10);
    for (int i = 0; i < 400; i++) step(0, ($urandom % 3) != 0);
    run(40);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule